// File: doc/BRIEF.md
# Two-level interrupt controller

This block gathers single-cycle event pulses from a number of sub-blocks and turns them into one active-high interrupt request for the host. Each sub-block owns a group of latched flags, where each flag names one cause. Each group has its own mask register. Every group reduces to one summary bit, and each summary bit names the sub-block that is raising a request. The summary bits have a mask of their own. The interrupt line is high while any summary bit that is not masked is set.

Software reads and clears the tree through a simple register port. Writes take effect on the clock edge and reads are combinational. Flags are cleared by writing ones. A summary bit needs no clearing, because it falls once its unmasked flags are gone. While the power sequencer holds its reset-qualify input high, the output is forced low. Flags keep latching during that time, so a pending request shows on the line as soon as the qualifier drops. The summary width equals the number of sources, which must not exceed the register data width.

Top module: `irq_tree`

## Requirements
- R1: After reset all flags are 0, every mask bit (both levels) is 1, and `irq_o` is low.
- R2: Register map for source s (0 to N_SRC-1): flags at address 2s, second-level mask at 2s+1. The summary is read-only at 2·N_SRC and the first-level mask is at 2·N_SRC+1. Any other address reads 0, and writes to it change nothing. A mask bit of 1 hides the bit it covers.
- R3: An event pulse on `evt_i[s*EW+b]` sets flag b of source s at the next clock edge. The flag stays set until a write of 1 to that bit at the flag address. Written 0 bits leave their flags alone.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A set second-level mask bit keeps its flag out of the summary, but the flag still latches and reads back.
- R6: Summary bit s is the OR of the flags of source s whose second-level mask bits are 0. It falls once those flags are cleared.
- R7: A set first-level mask bit keeps its summary bit off `irq_o`, while the summary register still shows it.
- R8: An event that is unmasked at both levels raises `irq_o` one clock after the pulse is sampled, provided `pwr_rst_i` is low.
- R9: While `pwr_rst_i` is high `irq_o` is low and flags still latch. When it falls with a request pending, `irq_o` rises in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | N_SRC*EW | Event pulses, EW bits per source |
| pwr_rst_i | input | 1 | Reset qualifier from the power sequencer; forces `irq_o` low while high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | EW | Write data |
| reg_rdata_o | output | EW | Read data for `reg_addr_i` |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The latency property assumes that a mask write never lands in the same cycle as an event it would affect. In that cycle the new mask, not the current one, decides the outcome, so the property excuses any cycle with a write. The stimulus issues mask writes only in cycles without events. The one deliberate collision is a clearing write to the flag address, which exercises the set-wins rule. Event pulses are held low during reset, so the latching properties never see an event before the first sampled edge.

// File: rtl/irq_tree.sv
module irq_tree #(
  parameter int N_SRC = 8,
  parameter int EW    = 8,
  localparam int AW   = $clog2(2 * N_SRC + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC*EW-1:0]   evt_i,
  input  logic                  pwr_rst_i,
  input  logic                  reg_we_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [EW-1:0]         reg_wdata_i,
  output logic [EW-1:0]         reg_rdata_o,
  output logic                  irq_o
);

  localparam int SUM_ADDR = 2 * N_SRC;
  localparam int TOP_MASK = 2 * N_SRC + 1;

  logic [N_SRC*EW-1:0] flag_q;
  logic [N_SRC*EW-1:0] mask2_q;
  logic [N_SRC-1:0]    mask1_q;
  logic [N_SRC-1:0]    l1;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic          wr_flag, wr_mask;
    logic [EW-1:0] clr;

    assign wr_flag = reg_we_i && (reg_addr_i == AW'(2 * s));
    assign wr_mask = reg_we_i && (reg_addr_i == AW'(2 * s + 1));
    assign clr     = wr_flag ? reg_wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[s*EW +: EW]  <= '0;
        mask2_q[s*EW +: EW] <= '1;
      end else begin
        flag_q[s*EW +: EW] <= (flag_q[s*EW +: EW] & ~clr) | evt_i[s*EW +: EW];
        if (wr_mask) mask2_q[s*EW +: EW] <= reg_wdata_i;
      end
    end

    assign l1[s] = |(flag_q[s*EW +: EW] & ~mask2_q[s*EW +: EW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask1_q <= '1;
    else if (reg_we_i && reg_addr_i == AW'(TOP_MASK))
      mask1_q <= reg_wdata_i[N_SRC-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (reg_addr_i == AW'(2 * s))     reg_rdata_o = flag_q[s*EW +: EW];
      if (reg_addr_i == AW'(2 * s + 1)) reg_rdata_o = mask2_q[s*EW +: EW];
    end
    if (reg_addr_i == AW'(SUM_ADDR)) reg_rdata_o = EW'(l1);
    if (reg_addr_i == AW'(TOP_MASK)) reg_rdata_o = EW'(mask1_q);
  end

  assign irq_o = !pwr_rst_i && |(l1 & ~mask1_q);

endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk #(
  parameter int N_SRC = 8,
  parameter int EW    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_SRC*EW-1:0] evt_i,
  input logic                pwr_rst_i,
  input logic                reg_we_i,
  input logic                irq_o,
  input logic [N_SRC*EW-1:0] flag_q,
  input logic [N_SRC*EW-1:0] mask2_q,
  input logic [N_SRC-1:0]    mask1_q
);

  logic vis;
  always_comb begin
    vis = 1'b0;
    for (int s = 0; s < N_SRC; s++)
      if (!mask1_q[s] && |(evt_i[s*EW +: EW] & ~mask2_q[s*EW +: EW])) vis = 1'b1;
  end

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_rst_i |-> !irq_o); // R9

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R3

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0)); // R3

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && !pwr_rst_i && !reg_we_i) |=> (irq_o || pwr_rst_i)); // R8

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($countones(flag_q & ~mask2_q) != 0)); // R6

endmodule

bind irq_tree irq_tree_chk #(.N_SRC(N_SRC), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .pwr_rst_i(pwr_rst_i),
  .reg_we_i(reg_we_i), .irq_o(irq_o), .flag_q(flag_q),
  .mask2_q(mask2_q), .mask1_q(mask1_q)
);

// File: tb/tb_irq_tree.sv
`timescale 1ns/10ps
module tb_irq_tree;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int AW = $clog2(2 * N + 2);

  logic clk = 0, rst_n = 0;
  logic [N*W-1:0] evt = '0;
  logic pwr_rst = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic irq;

  int checks = 0, errors = 0;
  logic [W-1:0] m_flag [N];
  logic [W-1:0] m_m2   [N];
  logic [N-1:0] m_m1;

  irq_tree #(.N_SRC(N), .EW(W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .pwr_rst_i(pwr_rst),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  always #4 clk = ~clk;

  function automatic logic [N-1:0] exp_l1();
    logic [N-1:0] v;
    for (int s = 0; s < N; s++) v[s] = |(m_flag[s] & ~m_m2[s]);
    return v;
  endfunction

  function automatic logic [W-1:0] exp_reg(int a);
    if (a < 2 * N) return (a % 2 == 0) ? m_flag[a/2] : m_m2[a/2];
    if (a == 2 * N) return W'(exp_l1());
    if (a == 2 * N + 1) return W'(m_m1);
    return '0;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(string tag);
    chk(tag, W'(irq), W'(!pwr_rst && |(exp_l1() & ~m_m1)));
  endtask

  task automatic chk_all(string tag);
    for (int a = 0; a < (1 << AW); a++) begin
      addr = AW'(a);
      #0.1;
      chk(tag, rdata, exp_reg(a));
    end
    chk_irq(tag);
  endtask

  task automatic step(logic [N*W-1:0] e, logic w, int a, logic [W-1:0] d);
    logic [W-1:0] clr;
    evt = e; we = w; addr = AW'(a); wdata = d;
    @(posedge clk);
    for (int s = 0; s < N; s++) begin
      clr = (w && a == 2 * s) ? d : '0;
      m_flag[s] = (m_flag[s] & ~clr) | e[s*W +: W];
      if (w && a == 2 * s + 1) m_m2[s] = d;
    end
    if (w && a == 2 * N + 1) m_m1 = d[N-1:0];
    @(negedge clk);
    evt = '0; we = 0; wdata = '0;
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    step('0, 1'b1, a, d);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) begin m_flag[s] = '0; m_m2[s] = '1; end
    m_m1 = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1 reset state");

    for (int s = 0; s < N; s++) wr(2 * s + 1, '0);
    wr(2 * N + 1, '0);
    chk_all("R2 masks opened");

    // R3 R6 R8: every flag bit, set then cleared with W1C
    for (int s = 0; s < N; s++)
      for (int b = 0; b < W; b++) begin
        logic [N*W-1:0] e;
        e = '0; e[s*W+b] = 1'b1;
        step(e, 1'b0, 0, '0);
        chk("R8 irq one cycle after event", W'(irq), 8'h01);
        chk_all("R3 R6 single flag set");
        wr(2 * s, ~(W'(1) << b));
        chk_all("R3 zero bits keep flag");
        wr(2 * s, W'(1) << b);
        chk_all("R6 summary falls after clear");
      end

    // R4 set wins over same-cycle clear
    step({N*W{1'b0}} | (64'h1 << 3), 1'b0, 0, '0);
    step({N*W{1'b0}} | (64'h1 << 3), 1'b1, 0, 8'h08);
    chk("R4 set wins", m_flag[0], 8'h08);
    chk_all("R4 set wins");
    wr(0, 8'hFF);
    chk_all("R4 cleared after");

    // R5 second-level mask hides but latches
    wr(2 * 2 + 1, 8'h10);
    step(64'h1 << (2 * W + 4), 1'b0, 0, '0);
    chk("R5 masked irq low", W'(irq), 8'h00);
    chk_all("R5 masked flag latched");
    wr(2 * 2 + 1, 8'h00);
    chk("R5 unmask exposes", W'(irq), 8'h01);
    chk_all("R5 unmasked");
    wr(4, 8'hFF);

    // R7 first-level mask
    wr(2 * N + 1, 8'h20);
    step(64'h1 << (5 * W + 7), 1'b0, 0, '0);
    chk("R7 top mask irq low", W'(irq), 8'h00);
    chk_all("R7 summary still shows");
    wr(2 * N + 1, 8'h00);
    chk_all("R7 top unmask");

    // R2 writes to summary and unused addresses ignored
    wr(2 * N, 8'h00);
    for (int a = 2 * N + 2; a < (1 << AW); a++) wr(a, 8'hFF);
    chk_all("R2 ignored writes");
    wr(10, 8'hFF);

    // R9 reset qualifier
    pwr_rst = 1;
    step(64'h1 << (7 * W), 1'b0, 0, '0);
    chk("R9 held low", W'(irq), 8'h00);
    chk_all("R9 flags latch while held");
    pwr_rst = 0;
    #0.1;
    chk("R9 released", W'(irq), 8'h01);
    chk_all("R9 released");

    // multi-source pattern
    step({8'hA5, 8'h00, 8'h3C, 8'h00, 8'h81, 8'h00, 8'h00, 8'h00}, 1'b0, 0, '0);
    wr(2 * 7 + 1, 8'hA5);
    chk_all("R6 mixed pattern");
    wr(2 * N + 1, 8'hFF);
    chk_all("R7 all top masked");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule